// File: doc/BRIEF.md
# Routed Programmable Interrupt Controller

The controller collects a vector of level-sensitive hardware interrupt inputs and a second group of software-only sources. It holds one pending bit per source and drives a small set of CPU interrupt lines. Each source owns a configuration word with an enable flag, a 4-bit target line number and a stored thread-ID value. A CPU line is asserted while at least one pending, enabled source is routed to it.

Software reaches the block through a simple single-cycle bus slave port, with 64-bit data and byte addresses. The port has four regions. The configuration array starts at 0x000, with source i at byte offset i×8. The pending-status read window is at 0x400. The write-one-to-set window is at 0x480 and the write-one-to-clear window is at 0x500. Each window is two 64-bit words: the word at offset +0 covers sources 0..63 and the word at +8 covers sources 64..127. Hardware sources are numbered 0..63 and software sources 64..127.

A hardware input that is seen high latches its pending bit. The bit then stays set until software clears it. Software sources become pending only through the set window.

Top module: `rpic`

## Requirements
- R1: After reset, all configuration words read as zero, both pending words read as zero, `cpu_irq` is all zero and `bus_rdata` is zero.
- R2: A configuration word keeps only bit 31 (enable), bits 30:8 (thread ID) and bits 3:0 (target line). All other bits read back as zero, so writing all ones reads back 0x00000000FFFFFF0F.
- R3: Writing zero to a configuration word disables the source. From the cycle after the write, that source drives no CPU line, and the word reads back zero.
- R4: A hardware input sampled high at a clock edge sets its pending bit from that edge on. The bit stays set after the input drops, including when the input was high for only one cycle.
- R5: A write to the set window sets every pending bit whose data bit is 1 and leaves the others alone. Data bit k of the word at 0x488 sets source 64+k. Software sources (64..127) become pending only this way.
- R6: A write to the clear window clears every pending bit whose data bit is 1. If a hardware input is high in the same cycle as the clear, its bit stays pending.
- R7: A read strobe returns data on `bus_rdata` one cycle later, and the value holds until the next read. The word at 0x400 reads pending bits 0..63 and the word at 0x408 reads bits 64..127. The set window, the clear window and unmapped addresses read as zero.
- R8: `cpu_irq[l]` is 1 exactly when some source is pending, has enable 1 and has a line field equal to l. A line field of NUM_LINES or more drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_HW | Level-sensitive hardware interrupt inputs |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| cpu_irq | output | NUM_LINES | CPU interrupt lines |

## Verification
Two functions can land in the same cycle: a clear-window write and a hardware input that is still high. Both update the same pending bit at one edge. The bench provokes this with a directed case, clearing source 7 while its input is held high, and then reading the pending word, which must still show the bit. The same overlap also comes up many times in the random phase. There, a behavioural model applies the rule "clear first, then the level ORs back in" and is compared against `cpu_irq` and `bus_rdata` on every clock.

// File: rtl/rpic.sv
module rpic #(
  parameter int NUM_HW    = 64,
  parameter int NUM_SW    = 64,
  parameter int NUM_LINES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HW-1:0]    hw_irq,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [10:0]          bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic [NUM_LINES-1:0] cpu_irq
);
  localparam int NUM_SRC = NUM_HW + NUM_SW;
  localparam int NWORDS  = NUM_SRC / 64;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int WW      = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int TID_W   = 23;
  localparam int LINE_W  = 4;
  localparam logic [10:0] CFG_END   = 11'h400;
  localparam logic [10:0] PEND_BASE = 11'h400;
  localparam logic [10:0] SET_BASE  = 11'h480;
  localparam logic [10:0] CLR_BASE  = 11'h500;
  localparam logic [10:0] WIN_BYTES = 11'(NWORDS * 8);

  logic              cfg_en   [NUM_SRC];
  logic [TID_W-1:0]  cfg_tid  [NUM_SRC];
  logic [LINE_W-1:0] cfg_line [NUM_SRC];
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] set_mask, clr_mask;
  logic [63:0] rd_mux;

  wire wr_acc = bus_sel & bus_wr;
  wire rd_acc = bus_sel & ~bus_wr;
  wire in_cfg = bus_addr < CFG_END;
  wire [IDX_W-1:0] idx = bus_addr[IDX_W+2:3];

  wire [10:0] pend_off = bus_addr - PEND_BASE;
  wire [10:0] set_off  = bus_addr - SET_BASE;
  wire [10:0] clr_off  = bus_addr - CLR_BASE;
  wire pend_hit = (bus_addr >= PEND_BASE) && (pend_off < WIN_BYTES);
  wire set_hit  = (bus_addr >= SET_BASE)  && (set_off  < WIN_BYTES);
  wire clr_hit  = (bus_addr >= CLR_BASE)  && (clr_off  < WIN_BYTES);

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (wr_acc && set_hit && set_off[WW+2:3] == WW'(w)) set_mask[64*w +: 64] = bus_wdata;
      if (wr_acc && clr_hit && clr_off[WW+2:3] == WW'(w)) clr_mask[64*w +: 64] = bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | {{NUM_SW{1'b0}}, hw_irq} | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        cfg_en[s]   <= 1'b0;
        cfg_tid[s]  <= '0;
        cfg_line[s] <= '0;
      end
    end else if (wr_acc && in_cfg) begin
      cfg_en[idx]   <= bus_wdata[31];
      cfg_tid[idx]  <= bus_wdata[30:8];
      cfg_line[idx] <= bus_wdata[3:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_cfg) rd_mux = {32'b0, cfg_en[idx], cfg_tid[idx], 4'b0, cfg_line[idx]};
    else if (pend_hit)
      for (int w = 0; w < NWORDS; w++)
        if (pend_off[WW+2:3] == WW'(w)) rd_mux = pend[64*w +: 64];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      cpu_irq[l] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (cfg_en[s] && pend[s] && cfg_line[s] == LINE_W'(l)) cpu_irq[l] = 1'b1;
    end
  end

  AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && in_cfg) |=> (bus_rdata[63:32] == 32'b0 && bus_rdata[7:4] == 4'b0)); // R2
  AST_HW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_irq != '0) |=> ((pend[NUM_HW-1:0] & $past(hw_irq)) == $past(hw_irq))); // R4
  AST_SW_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0) |=> ((pend[NUM_SRC-1:NUM_HW] & ~$past(pend[NUM_SRC-1:NUM_HW])) == '0)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((pend & $past(pend)) == $past(pend))); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata)); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq != '0) |-> (pend != '0)); // R8
endmodule

// File: tb/rpic_bench.sv
module rpic_bench;
  localparam int NL = 5;
  localparam logic [63:0] CFG_KEEP = 64'h0000_0000_FFFF_FF0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] hw_irq = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [NL-1:0] cpu_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rpic #(.NUM_HW(64), .NUM_SW(64), .NUM_LINES(NL)) u_rpic (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  logic [63:0]  m_cfg [128];
  logic [127:0] m_pend;
  logic [63:0]  m_rdata;

  function automatic logic [63:0] m_read(input logic [10:0] a);
    if (a < 11'h400) return m_cfg[a[9:3]];
    if (a == 11'h400 || a == 11'h401 || (a >= 11'h400 && a < 11'h408)) return m_pend[63:0];
    if (a >= 11'h408 && a < 11'h410) return m_pend[127:64];
    return 64'h0;
  endfunction

  function automatic logic [NL-1:0] m_irq();
    logic [NL-1:0] r = '0;
    for (int s = 0; s < 128; s++)
      if (m_cfg[s][31] && m_pend[s] && m_cfg[s][3:0] < NL) r[m_cfg[s][3:0]] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    logic [127:0] sm, cm;
    sm = '0; cm = '0;
    if (!rst_n) begin
      for (int s = 0; s < 128; s++) m_cfg[s] = '0;
      m_pend = '0;
      m_rdata = '0;
    end else begin
      if (bus_sel && !bus_wr) m_rdata = m_read(bus_addr);
      if (bus_sel && bus_wr) begin
        if (bus_addr < 11'h400) m_cfg[bus_addr[9:3]] = bus_wdata & CFG_KEEP;
        else if (bus_addr >= 11'h480 && bus_addr < 11'h488) sm[63:0] = bus_wdata;
        else if (bus_addr >= 11'h488 && bus_addr < 11'h490) sm[127:64] = bus_wdata;
        else if (bus_addr >= 11'h500 && bus_addr < 11'h508) cm[63:0] = bus_wdata;
        else if (bus_addr >= 11'h508 && bus_addr < 11'h510) cm[127:64] = bus_wdata;
      end
      m_pend = (m_pend & ~cm) | {64'b0, hw_irq} | sm;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (cpu_irq !== m_irq()) begin
        errors++;
        $display("FAIL R8 cycle compare cpu_irq act=%h exp=%h", cpu_irq, m_irq());
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R7 cycle compare bus_rdata act=%h exp=%h", bus_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu_irq after reset", 64'(cpu_irq), 64'h0);
    chk("R1 rdata after reset", bus_rdata, 64'h0);
    rd(11'h400, d); chk("R1 pend lo", d, 64'h0);
    rd(11'h408, d); chk("R1 pend hi", d, 64'h0);
    rd(11'h028, d); chk("R1 cfg 5", d, 64'h0);

    wr(11'h018, '1);
    rd(11'h018, d); chk("R2 cfg mask", d, 64'h0000_0000_FFFF_FF0F);

    wr(11'h010, 64'h8000_0001);
    hw_irq[2] = 1'b1;
    @(negedge clk);
    chk("R8 src2 on line1", 64'(cpu_irq), 64'h2);
    wr(11'h010, 64'h0);
    chk("R3 disabled by zero", 64'(cpu_irq), 64'h0);
    rd(11'h010, d); chk("R3 cfg reads zero", d, 64'h0);
    hw_irq[2] = 1'b0;
    rd(11'h400, d); chk("R4 src2 sticky", d, 64'h4);

    @(negedge clk); hw_irq[10] = 1'b1;
    @(negedge clk); hw_irq[10] = 1'b0;
    rd(11'h400, d); chk("R4 one-cycle pulse latched", d, 64'h404);

    wr(11'h500, 64'h404);
    rd(11'h400, d); chk("R6 clear", d, 64'h0);
    hw_irq[7] = 1'b1;
    @(negedge clk);
    wr(11'h500, 64'h80);
    rd(11'h400, d); chk("R6 level wins over clear", d, 64'h80);
    hw_irq[7] = 1'b0;
    wr(11'h500, 64'h80);
    rd(11'h400, d); chk("R6 clear after drop", d, 64'h0);

    wr(11'h488, 64'h20);
    rd(11'h408, d); chk("R5 sw source 69 pending", d, 64'h20);
    rd(11'h400, d); chk("R5 hw word untouched", d, 64'h0);
    rd(11'h488, d); chk("R7 set window reads zero", d, 64'h0);
    wr(11'h228, 64'h8000_0004);
    chk("R5 src69 on line4", 64'(cpu_irq), 64'h10);

    wr(11'h230, 64'h8000_0009);
    wr(11'h488, 64'h40);
    chk("R8 line 9 drives nothing", 64'(cpu_irq), 64'h10);
    wr(11'h238, 64'h8012_3404);
    wr(11'h488, 64'h80);
    wr(11'h508, 64'h20);
    chk("R8 OR keeps line4 via src71", 64'(cpu_irq), 64'h10);
    wr(11'h508, 64'h80);
    chk("R8 line4 drops", 64'(cpu_irq), 64'h0);
    rd(11'h238, d); chk("R2 tid kept", d, 64'h8012_3404);

    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      @(negedge clk);
      hw_irq = ($urandom_range(0, 3) == 0) ? (64'(1) << $urandom_range(0, 63)) : 64'h0;
      bus_sel = 1'b0; bus_wr = 1'b0;
      case (op)
        0, 1: begin bus_sel = 1'b1; bus_addr = 11'($urandom_range(0, 127) * 8); end
        2:    begin bus_sel = 1'b1; bus_addr = 11'h400 + 11'($urandom_range(0, 1) * 8); end
        3:    begin bus_sel = 1'b1; bus_addr = 11'($urandom_range(0, 2047)); end
        4:    begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 11'($urandom_range(0, 127) * 8);
                    bus_wdata = {$urandom, $urandom(), 1'b0, 3'b0} ^ {32'h0, 1'($urandom_range(0,1)), 27'h0, 4'($urandom_range(0, 7))}; end
        5:    begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 11'h480 + 11'($urandom_range(0, 1) * 8);
                    bus_wdata = {$urandom, $urandom}; end
        6:    begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 11'h500 + 11'($urandom_range(0, 1) * 8);
                    bus_wdata = {$urandom, $urandom}; end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_sel = 1'b0; hw_irq = '0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule